// File: doc/BRIEF.md
# Word FIFO Bit-Serial Loader

This block is the input buffer in front of a cyclic-code engine. A host pushes 24-bit words into it by writing again and again to one register address. The block keeps up to five words, which is 120 bits. When the engine asks for a run, the block streams the buffered bits out one per clock. The bits go least significant bit first, and the stream runs on across word boundaries.

A start pulse carries an 8-bit count of the bits wanted and a per-target enable mask. Each enabled downstream shift register gets a strobe for every bit emitted. A done pulse marks the final bit. Any buffered bits beyond the count are thrown away when the run finishes. Bits asked for past the end of the buffered data come out as zeros and raise an underflow flag. Writes that find the buffer full are dropped and raise a sticky overflow flag.

Top module: `wfifo_serial_loader`

## Requirements
- R1: After a synchronous reset, busy, done, ser_bit, every tgt_strobe bit, overflow and underflow are all 0, and the buffer holds no words.
- R2: The buffer holds five 24-bit words. Each accepted host write appends one word, and words leave in the order they were written.
- R3: Bits are emitted least significant bit first. After bit 23 of one word, the next bit emitted is bit 0 of the next word.
- R4: A start with a non-zero bit_count N, taken while idle, makes the block emit N bits, one per clock. The first bit is on ser_bit one clock after the edge that captured start. busy is 0 again once the last bit has been shown.
- R5: done is 1 for exactly one cycle, in the same cycle as the last emitted bit.
- R6: tgt_mask is captured at start. During each emitted bit, tgt_strobe equals the captured mask. Changing tgt_mask during a run has no effect on the strobes.
- R7: When a run completes, every bit still buffered is discarded. The next run uses only words written after that point.
- R8: A host write is dropped if it arrives while five words are buffered and no word is retired in that cycle. The drop sets overflow, and overflow stays 1 until reset.
- R9: Host writes are accepted during a run. A write into a full buffer in the same cycle that a word is retired is accepted, and it does not set overflow.
- R10: A bit asked for when no word is buffered is emitted as 0 and sets underflow. underflow stays 1 until the next accepted start clears it.
- R11: A start that arrives while busy, or with bit_count equal to 0, is ignored. It does not change the run length, and it does not begin a run.
- R12: A reset in the middle of a run stops the run at once and empties the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe to the buffer address |
| wr_data | input | 24 | Host write word |
| start | input | 1 | Run request pulse |
| bit_count | input | 8 | Number of bits to emit in the run |
| tgt_mask | input | 3 | Per-target enable, captured at start |
| ser_bit | output | 1 | Serial data bit |
| tgt_strobe | output | 3 | Per-target shift strobe for ser_bit |
| done | output | 1 | Pulse with the last bit of a run |
| busy | output | 1 | A run is in progress |
| overflow | output | 1 | Sticky flag for a dropped write |
| underflow | output | 1 | A run asked for more bits than were buffered |

## Verification
Two functions can fall in the same cycle: a host write arriving while the buffer is full, and the sequencer retiring the head word after its bit 23. The bench fills all five slots and starts a 144-bit run. It then times a sixth write so that it is captured on the very edge that emits bit 23 of the first word. The write passes if overflow stays clear, underflow stays clear, and bits 120 to 143 of the stream match the sixth word.

// File: rtl/wfsl_pkg.sv
package wfsl_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } seq_state_t;
endpackage

// File: rtl/wfsl_word_fifo.sv
module wfsl_word_fifo #(
  parameter int WORD_W = 24,
  parameter int DEPTH  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              pop,
  input  logic              flush,
  output logic [WORD_W-1:0] rd_word,
  output logic              empty,
  output logic              overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [LVL_W-1:0]  level;
  logic              is_full, do_push;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign is_full = (level == LVL_W'(DEPTH));
  // A slot freed by a flush or a retire this cycle may be refilled at once.
  assign do_push = wr_en && (flush || !is_full || pop);

  // Storage without reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_en && !do_push) overflow <= 1'b1;
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (flush) begin
        rd_ptr <= wr_ptr;
        level  <= do_push ? LVL_W'(1) : '0;
      end else begin
        if (pop) rd_ptr <= ptr_inc(rd_ptr);
        case ({do_push, pop})
          2'b10:   level <= level + LVL_W'(1);
          2'b01:   level <= level - LVL_W'(1);
          default: level <= level;
        endcase
      end
    end
  end

  assign rd_word = mem[rd_ptr];
  assign empty   = (level == '0);

  // R2: the occupancy never exceeds the configured depth
  a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));

  // R3: the sequencer retires a word only when one is buffered
  a_r3_pop_needs_word: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

  // R8: once set, overflow stays set until reset
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(overflow)) |-> overflow);
endmodule

// File: rtl/wfsl_bit_seq.sv
module wfsl_bit_seq
  import wfsl_pkg::*;
#(
  parameter int WORD_W  = 24,
  parameter int CNT_W   = 8,
  parameter int NUM_TGT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [CNT_W-1:0]   bit_count,
  input  logic [NUM_TGT-1:0] tgt_mask,
  input  logic [WORD_W-1:0]  rd_word,
  input  logic               empty,
  output logic               pop,
  output logic               flush,
  output logic               emit,
  output logic               emit_bit,
  output logic               last,
  output logic [NUM_TGT-1:0] mask_q,
  output logic               busy,
  output logic               underflow
);
  localparam int IDX_W = $clog2(WORD_W);

  seq_state_t       state_q;
  logic [CNT_W-1:0] remain_q;
  logic [IDX_W-1:0] idx_q;
  logic             at_top;

  assign emit     = (state_q == ST_SHIFT);
  assign at_top   = (idx_q == IDX_W'(WORD_W - 1));
  assign emit_bit = emit && !empty && rd_word[idx_q];
  assign last     = emit && (remain_q == CNT_W'(1));
  assign pop      = emit && !empty && at_top;
  assign flush    = last;
  assign busy     = emit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      remain_q  <= '0;
      idx_q     <= '0;
      mask_q    <= '0;
      underflow <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start && (bit_count != '0)) begin
            state_q   <= ST_SHIFT;
            remain_q  <= bit_count;
            mask_q    <= tgt_mask;
            idx_q     <= '0;
            underflow <= 1'b0;
          end
        end
        default: begin
          remain_q <= remain_q - CNT_W'(1);
          if (empty) underflow <= 1'b1;
          else       idx_q <= at_top ? '0 : idx_q + IDX_W'(1);
          if (last) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
          end
        end
      endcase
    end
  end

  // R10: a bit taken from an empty buffer raises underflow
  a_r10_empty_flags_underflow: assert property (@(posedge clk) disable iff (rst)
    (emit && empty) |=> underflow);
endmodule

// File: rtl/wfsl_fanout.sv
module wfsl_fanout #(
  parameter int NUM_TGT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               emit,
  input  logic               emit_bit,
  input  logic               last,
  input  logic [NUM_TGT-1:0] mask_q,
  output logic               ser_bit,
  output logic [NUM_TGT-1:0] tgt_strobe,
  output logic               done
);
  for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
    always_ff @(posedge clk) begin
      if (rst) tgt_strobe[g] <= 1'b0;
      else     tgt_strobe[g] <= emit && mask_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_bit <= 1'b0;
      done    <= 1'b0;
    end else begin
      ser_bit <= emit && emit_bit;
      done    <= last;
    end
  end

  // R5: done never lasts more than one cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/wfifo_serial_loader.sv
module wfifo_serial_loader #(
  parameter int WORD_W  = 24,
  parameter int DEPTH   = 5,
  parameter int CNT_W   = 8,
  parameter int NUM_TGT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic               start,
  input  logic [CNT_W-1:0]   bit_count,
  input  logic [NUM_TGT-1:0] tgt_mask,
  output logic               ser_bit,
  output logic [NUM_TGT-1:0] tgt_strobe,
  output logic               done,
  output logic               busy,
  output logic               overflow,
  output logic               underflow
);
  logic [WORD_W-1:0]  rd_word;
  logic               empty, pop, flush, emit, emit_bit, last;
  logic [NUM_TGT-1:0] mask_q;

  wfsl_word_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .pop(pop), .flush(flush), .rd_word(rd_word), .empty(empty),
    .overflow(overflow)
  );

  wfsl_bit_seq #(.WORD_W(WORD_W), .CNT_W(CNT_W), .NUM_TGT(NUM_TGT)) u_seq (
    .clk(clk), .rst(rst), .start(start), .bit_count(bit_count),
    .tgt_mask(tgt_mask), .rd_word(rd_word), .empty(empty), .pop(pop),
    .flush(flush), .emit(emit), .emit_bit(emit_bit), .last(last),
    .mask_q(mask_q), .busy(busy), .underflow(underflow)
  );

  wfsl_fanout #(.NUM_TGT(NUM_TGT)) u_out (
    .clk(clk), .rst(rst), .emit(emit), .emit_bit(emit_bit), .last(last),
    .mask_q(mask_q), .ser_bit(ser_bit), .tgt_strobe(tgt_strobe), .done(done)
  );

  // R5: a run only ends together with its done pulse
  a_r5_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> done);
endmodule

// File: tb/wfifo_serial_loader_test.sv
module wfifo_serial_loader_test;
  localparam int NT = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [23:0]   wr_data = '0;
  logic          start = 1'b0;
  logic [7:0]    bit_count = '0;
  logic [NT-1:0] tgt_mask = '0;
  logic          ser_bit, done, busy, overflow, underflow;
  logic [NT-1:0] tgt_strobe;

  int checks = 0;
  int errors = 0;
  logic [23:0] mw [8];
  int mcount = 0;

  always #2.5 clk = ~clk;

  wfifo_serial_loader uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .start(start),
    .bit_count(bit_count), .tgt_mask(tgt_mask), .ser_bit(ser_bit),
    .tgt_strobe(tgt_strobe), .done(done), .busy(busy),
    .overflow(overflow), .underflow(underflow)
  );

  // rows: words to write, bits to request, target mask
  localparam int VEC [7][3] = '{
    '{5, 120, 7}, '{1, 24, 1}, '{2, 10, 2}, '{1, 24, 4},
    '{3, 50, 5}, '{2, 60, 6}, '{4, 1, 3}
  };

  function automatic logic [23:0] pat(input int s);
    return 24'(s * 32'h009E3779) ^ 24'hC3A55A;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
    if (mcount < 5) begin mw[mcount] = w; mcount++; end
  endtask

  task automatic run(input int nbits, input logic [NT-1:0] mask,
                     input int wr_at, input logic [23:0] xw, input int poke_at);
    int bad_bits = 0;
    int bad_str = 0;
    int bad_done = 0;
    logic exp_b;
    logic exp_und;
    if (wr_at >= 0) begin mw[mcount] = xw; mcount++; end
    exp_und = (nbits > 24 * mcount);
    @(negedge clk); bit_count = 8'(nbits); tgt_mask = mask; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      exp_b = ((k / 24) < mcount) ? mw[k / 24][k % 24] : 1'b0;
      if (ser_bit !== exp_b) bad_bits++;
      if (tgt_strobe !== mask) bad_str++;
      if (done !== (k == nbits - 1)) bad_done++;
      wr_en = (k == wr_at);
      wr_data = xw;
      if (k == poke_at) begin
        start = 1'b1; bit_count = 8'd3; tgt_mask = ~mask;
      end else start = 1'b0;
    end
    @(negedge clk); wr_en = 1'b0; start = 1'b0;
    chk(bad_bits == 0, "R3", "bit stream mismatches", bad_bits, 0);
    chk(bad_str == 0, "R6", "strobe mismatches", bad_str, 0);
    chk(bad_done == 0, "R5", "done mismatches", bad_done, 0);
    chk(!busy && !done && tgt_strobe == '0, "R4", "idle after run",
        {busy, done, tgt_strobe}, 0);
    chk(underflow == exp_und, "R10", "underflow", underflow, exp_und);
    mcount = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", "timeout", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !ser_bit && tgt_strobe == '0 && !overflow && !underflow,
        "R1", "reset outputs", {busy, done, ser_bit, tgt_strobe, overflow, underflow}, 0);

    // R2 R3 R4 R7: table of fill and run patterns
    for (int i = 0; i < 7; i++) begin
      for (int j = 0; j < VEC[i][0]; j++) wr(pat(i * 8 + j));
      run(VEC[i][1], NT'(VEC[i][2]), -1, '0, -1);
    end

    // R11: zero count start is ignored, buffer kept
    wr(pat(100));
    @(negedge clk); bit_count = 8'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(!busy && tgt_strobe == '0, "R11", "zero count start", busy, 0);
    run(24, 3'b010, -1, '0, -1);

    // R9 R6 R11: full buffer, write on retire edge, mask change and restart mid-run
    for (int j = 0; j < 5; j++) wr(pat(200 + j));
    run(144, 3'b011, 22, pat(300), 5);
    chk(!overflow, "R9", "write on retire cycle kept", overflow, 0);

    // R8 R10: sixth write dropped, missing bits read as zeros
    for (int j = 0; j < 6; j++) wr(pat(400 + j));
    chk(overflow, "R8", "overflow after sixth write", overflow, 1);
    run(130, 3'b111, -1, '0, -1);
    wr(pat(500));
    run(8, 3'b001, -1, '0, -1);
    chk(overflow, "R8", "overflow sticky", overflow, 1);
    chk(!underflow, "R10", "underflow cleared by start", underflow, 0);

    // R12: reset mid-run
    for (int j = 0; j < 3; j++) wr(pat(600 + j));
    @(negedge clk); bit_count = 8'd60; tgt_mask = 3'b111; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(!busy && tgt_strobe == '0 && !overflow && !underflow, "R12", "reset mid-run",
        {busy, tgt_strobe, overflow, underflow}, 0);
    mcount = 0;
    wr(pat(700));
    run(24, 3'b100, -1, '0, -1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule